// File: doc/BRIEF.md
# Three-Tap Weighted-Sum Sample Filter

This block is a fully parallel finite impulse response filter with three taps. It takes one 12-bit sample on every clock and moves it into a short delay line that holds the newest three samples. Each held sample is multiplied by its own weight. The three products are added, and the result goes into an output register. No controller or sequencer is involved: the datapath computes a new weighted sum on every cycle.

The three weights are written at run time over a shared weight bus. A 2-bit selector chooses the weight and a write strobe enables the write, so one weight changes per write cycle. The block fits anywhere a stream of samples needs light smoothing or shaping, with weights that a host or a neighbouring block can change while the stream runs.

Top module: `fir3_filter`

## Requirements
- R1: When `rst` is high at a clock edge, all sample, weight and output registers clear to zero. After that edge `y_out` reads 0, and with the weights cleared an impulse gives 0 on every output cycle.
- R2: On each clock edge the delay line shifts. `smp_in` becomes the newest tap, the newest tap becomes the middle tap, and the middle tap becomes the oldest tap. A single nonzero sample therefore weights the output by w0, then w1, then w2, and then leaves.
- R3: `y_out` equals w0·x(t) + w1·x(t−1) + w2·x(t−2). Samples and weights are treated as unsigned.
- R4: `y_out` is registered and trails the delay-line contents by one clock. A sample presented before edge e first affects `y_out` after edge e+1.
- R5: When `wt_wr` is high at an edge, selector code 0, 1 or 2 loads `wt_din` into w0, w1 or w2. The other two weights keep their values.
- R6: A write with selector code 3 changes no weight.
- R7: While `wt_wr` is low, no weight changes, whatever `wt_sel` and `wt_din` carry.
- R8: The sum is truncated to its low 12 bits. With all weights and all three taps at 4095, `y_out` is 3.
- R9: A weight written at edge e is first used in the sum that `y_out` shows after edge e+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_in | input | 12 | Sample taken on every clock |
| wt_wr | input | 1 | Weight write strobe |
| wt_sel | input | 2 | Weight selector (0, 1, 2 select w0, w1, w2; 3 selects none) |
| wt_din | input | 12 | Weight write data |
| y_out | output | 12 | Registered weighted sum, low 12 bits |

## Verification
The weights can only be seen through the filtered output, so the bench cannot read them directly. To observe them, it flushes the delay line with zeros and then pushes a single unit sample. The three output cycles that follow show w0, w1 and w2 one after another. The bench runs this impulse probe after each write it tests: a normal write, a write with code 3, and a cycle where the strobe is low but the selector and data change. For the timing of a weight change, it holds the samples constant and writes a weight in the middle of the stream, so the change shows up on exactly one output cycle.

// File: rtl/fir3_pkg.sv
`timescale 1ns/1ps
package fir3_pkg;
  typedef enum logic [1:0] {
    WSEL_W0   = 2'd0,
    WSEL_W1   = 2'd1,
    WSEL_W2   = 2'd2,
    WSEL_NONE = 2'd3
  } wsel_e;
endpackage

// File: rtl/fir3_delay_line.sv
`timescale 1ns/1ps
module fir3_delay_line #(
  parameter int SAMPLE_W = 12,
  parameter int TAPS     = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [SAMPLE_W-1:0]           smp_in,
  output logic [TAPS-1:0][SAMPLE_W-1:0] tap_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tap_q <= '0;
    end else begin
      tap_q[0] <= smp_in;
      for (int i = 1; i < TAPS; i++) begin
        tap_q[i] <= tap_q[i-1];
      end
    end
  end
endmodule

// File: rtl/fir3_weight_bank.sv
`timescale 1ns/1ps
module fir3_weight_bank #(
  parameter int COEF_W = 12,
  parameter int TAPS   = 3,
  parameter int ADDR_W = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           sel,
  input  logic [COEF_W-1:0]           din,
  output logic [TAPS-1:0][COEF_W-1:0] wt_q
);
  logic [TAPS-1:0] wr_hit;

  generate
    for (genvar g = 0; g < TAPS; g++) begin : g_dec
      assign wr_hit[g] = wr && (sel == ADDR_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wt_q <= '0;
    end else begin
      for (int i = 0; i < TAPS; i++) begin
        if (wr_hit[i]) wt_q[i] <= din;
      end
    end
  end
endmodule

// File: rtl/fir3_mac.sv
`timescale 1ns/1ps
module fir3_mac #(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 12,
  parameter int OUT_W    = 12,
  parameter int TAPS     = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [TAPS-1:0][SAMPLE_W-1:0] tap,
  input  logic [TAPS-1:0][COEF_W-1:0]   wt,
  output logic [OUT_W-1:0]              y_q
);
  localparam int PROD_W = SAMPLE_W + COEF_W;
  localparam int SUM_W  = PROD_W + $clog2(TAPS);

  logic [TAPS-1:0][SUM_W-1:0] prod;
  logic [SUM_W-1:0]           acc;
  logic                       unused_hi;

  generate
    for (genvar g = 0; g < TAPS; g++) begin : g_mul
      assign prod[g] = SUM_W'(tap[g]) * SUM_W'(wt[g]);
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int i = 0; i < TAPS; i++) begin
      acc = acc + prod[i];
    end
  end

  assign unused_hi = ^acc[SUM_W-1:OUT_W];

  always_ff @(posedge clk) begin
    if (rst) y_q <= '0;
    else     y_q <= acc[OUT_W-1:0];
  end
endmodule

// File: rtl/fir3_filter.sv
`timescale 1ns/1ps
module fir3_filter #(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 12,
  parameter int OUT_W    = 12,
  parameter int TAPS     = 3,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] smp_in,
  input  logic                wt_wr,
  input  logic [ADDR_W-1:0]   wt_sel,
  input  logic [COEF_W-1:0]   wt_din,
  output logic [OUT_W-1:0]    y_out
);
  logic [TAPS-1:0][SAMPLE_W-1:0] tap_w;
  logic [TAPS-1:0][COEF_W-1:0]   wt_w;

  fir3_delay_line #(.SAMPLE_W(SAMPLE_W), .TAPS(TAPS)) u_line (
    .clk(clk), .rst(rst), .smp_in(smp_in), .tap_q(tap_w)
  );

  fir3_weight_bank #(.COEF_W(COEF_W), .TAPS(TAPS), .ADDR_W(ADDR_W)) u_wts (
    .clk(clk), .rst(rst), .wr(wt_wr), .sel(wt_sel), .din(wt_din), .wt_q(wt_w)
  );

  fir3_mac #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .TAPS(TAPS)) u_mac (
    .clk(clk), .rst(rst), .tap(tap_w), .wt(wt_w), .y_q(y_out)
  );
endmodule

// File: rtl/fir3_checker.sv
`timescale 1ns/1ps
module fir3_checker #(
  parameter int SAMPLE_W = 12,
  parameter int COEF_W   = 12,
  parameter int OUT_W    = 12,
  parameter int TAPS     = 3,
  parameter int ADDR_W   = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wt_wr,
  input logic [ADDR_W-1:0]             wt_sel,
  input logic [COEF_W-1:0]             wt_din,
  input logic [TAPS-1:0][SAMPLE_W-1:0] taps,
  input logic [TAPS-1:0][COEF_W-1:0]   wts,
  input logic [OUT_W-1:0]              y_out
);
  localparam int SUM_W = SAMPLE_W + COEF_W + $clog2(TAPS);

  logic [SUM_W-1:0] ref_sum;
  logic             unused_ref;
  always_comb begin
    ref_sum = '0;
    for (int i = 0; i < TAPS; i++) ref_sum = ref_sum + SUM_W'(taps[i]) * SUM_W'(wts[i]);
  end
  assign unused_ref = ^ref_sum[SUM_W-1:OUT_W];

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (y_out == '0 && taps == '0 && wts == '0));

  generate
    for (genvar g = 1; g < TAPS; g++) begin : g_shift
      assert_chain_shift_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> taps[g] == $past(taps[g-1]));
    end
    for (genvar g = 0; g < TAPS; g++) begin : g_load
      assert_weight_load_R5: assert property (@(posedge clk) disable iff (rst)
        (wt_wr && wt_sel == ADDR_W'(g)) |=> wts[g] == $past(wt_din));
    end
  endgenerate

  // R3, R4: output equals the truncated sum of the previous cycle's taps and weights
  assert_sum_lag_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> y_out == $past(ref_sum[OUT_W-1:0]));

  assert_sel_none_R6: assert property (@(posedge clk) disable iff (rst)
    (wt_wr && wt_sel == ADDR_W'(3)) |=> $stable(wts));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wt_wr |=> $stable(wts));
endmodule

bind fir3_filter fir3_checker #(
  .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .TAPS(TAPS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wt_wr(wt_wr), .wt_sel(wt_sel), .wt_din(wt_din),
  .taps(tap_w), .wts(wt_w), .y_out(y_out)
);

// File: tb/sim_fir3_filter.sv
`timescale 1ns/1ps
module sim_fir3_filter;
  localparam int NV = 16;
  localparam logic [11:0] VEC [NV] = '{
    12'd100, 12'd102, 12'd99,  12'd4000, 12'd101, 12'd98,  12'd0,    12'd4095,
    12'd7,   12'd2048, 12'd2047, 12'd1,  12'd300,  12'd301, 12'd1234, 12'd17
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] smp;
  logic        wr;
  logic [1:0]  sel;
  logic [11:0] din;
  logic [11:0] y;

  always #2.5 clk = ~clk;

  fir3_filter u0 (
    .clk(clk), .rst(rst), .smp_in(smp), .wt_wr(wr), .wt_sel(sel), .wt_din(din), .y_out(y)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int m_tap [3];
  int m_wt  [3];
  int m_y;

  // Reference model built from R1..R9, advanced once per clock edge
  task automatic tick();
    int s;
    @(posedge clk);
    s = 0;
    for (int k = 0; k < 3; k++) s += m_tap[k] * m_wt[k];
    if (rst) begin
      m_y = 0;
      for (int k = 0; k < 3; k++) begin m_tap[k] = 0; m_wt[k] = 0; end
    end else begin
      m_y = s % 4096;
      m_tap[2] = m_tap[1]; m_tap[1] = m_tap[0]; m_tap[0] = int'(smp);
      if (wr && sel != 2'd3) m_wt[sel] = int'(din);
    end
    @(negedge clk);
  endtask

  task automatic check(input int exp, input string tag);
    n_cmp++;
    if (y !== exp[11:0]) begin
      n_bad++;
      $display("FAIL %s: y=%0d expected %0d", tag, y, exp);
    end
  endtask

  task automatic load(input logic [1:0] s, input logic [11:0] v);
    wr = 1'b1; sel = s; din = v;
    tick();
    wr = 1'b0;
  endtask

  task automatic flush();
    smp = '0;
    repeat (4) tick();
  endtask

  task automatic impulse(input int e0, input int e1, input int e2, input string tag);
    flush();
    smp = 12'd1; tick(); check(0, {tag, " R4 one-clock lag"});
    smp = '0;
    tick(); check(e0, {tag, " R2 newest tap"});
    tick(); check(e1, {tag, " R2 middle tap"});
    tick(); check(e2, {tag, " R2 oldest tap"});
    tick(); check(0,  {tag, " R2 drained"});
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; smp = 12'd55; wr = 1'b0; sel = '0; din = '0;
    for (int k = 0; k < 3; k++) begin m_tap[k] = 0; m_wt[k] = 0; end
    m_y = 0;
    @(negedge clk);
    repeat (3) tick();
    check(0, "R1 reset state");
    rst = 1'b0;

    load(2'd0, 12'd3);
    load(2'd1, 12'd5);
    load(2'd2, 12'd7);

    // table walk: R3 weighted sum over varied samples
    for (int i = 0; i < NV; i++) begin
      smp = VEC[i];
      tick();
      check(m_y, "R3 table vector");
    end

    impulse(3, 5, 7, "base");

    // R6: selector code 3 writes nothing
    load(2'd3, 12'd100);
    impulse(3, 5, 7, "R6 code3 ignored");

    // R7: strobe low, selector and data wiggle
    wr = 1'b0; sel = 2'd1; din = 12'd99;
    impulse(3, 5, 7, "R7 strobe low");

    // R5: only the selected weight changes
    load(2'd1, 12'd11);
    impulse(3, 11, 7, "R5 write w1");

    // R9: a weight written mid-stream is used one output cycle later
    smp = 12'd2;
    repeat (4) tick();
    check(42, "R9 before write");
    load(2'd0, 12'd20);
    check(42, "R9 write edge still old weight");
    tick();
    check(76, "R9 new weight in use");

    // R8: truncation to 12 bits at full scale
    load(2'd0, 12'd4095);
    load(2'd1, 12'd4095);
    load(2'd2, 12'd4095);
    smp = 12'd4095;
    repeat (4) tick();
    check(3, "R8 full-scale wrap");

    // R1: reset in mid-run clears weights too
    rst = 1'b1; tick();
    check(0, "R1 mid-run reset");
    rst = 1'b0;
    impulse(0, 0, 0, "R1 weights cleared");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule